// File: doc/BRIEF.md
# Linked Descriptor Fetch Sequencer

This block is the per-channel control engine of a memory-to-memory or memory-to-peripheral transfer unit. Software loads the address of a descriptor, then rings a doorbell. The engine reads the descriptor as eight 32-bit words over a word-wide read port. It captures the command, source, target and count words and hands them to a downstream data mover through a start pulse. When the mover reports done, the engine either follows the descriptor's link or finishes the list.

The link is not a full pointer. The top byte of the count word carries an offset, in 16-byte units, from the chain base. The chain base is the descriptor address latched at doorbell time. An offset of zero leads back to the base, so a ring of descriptors can run forever without ever raising a completion event. Completion status and the optional interrupt appear only after a descriptor whose link flag is clear. A read error during a fetch halts the channel with an address-error flag.

Top module: `chain_fetch_seq`

## Requirements
- R1: After reset the engine is idle: `busy`, `rdReq`, `moveStart`, `termDone`, `termIrq` and `addrErr` are all low.
- R2: A run starts only on a `doorbell` cycle while `chanEn` is high, and only if `descAddrWe` has been pulsed since the previous run started. A doorbell that does not meet these conditions leaves `busy` and `rdReq` low.
- R3: Each descriptor is read as eight words, one read outstanding at a time, from its address plus 0, 4, ..., 28. Word 0 is the command, word 1 the source, word 2 the target and word 3 the count. Words 4 to 7 are read and discarded.
- R4: One cycle after the eighth word is accepted, `moveStart` pulses for exactly one cycle. During that pulse it presents the source, the target, count bits 23:0 and the full command word. The engine then waits for `moveDone`.
- R5: When command bit 0 (link) is set, the next descriptor is fetched from the chain base plus count bits 31:24 times 16. The offset is added to the chain base, not to the current descriptor's address.
- R6: A linked offset of zero returns to the chain base. While descriptors stay linked, `termDone` and `termIrq` remain low.
- R7: After an unlinked descriptor completes, `termDone` is set and `busy` falls. `termIrq` pulses for one cycle only if command bit 1 (interrupt enable) is set.
- R8: A read response with `rdErr` high sets `addrErr` and returns the engine to idle. The partly read descriptor is not issued.
- R9: With `chanEn` low, the engine is idle at the next clock edge from any state, and `rdReq` and `moveStart` are held low.
- R10: Starting a new run clears `termDone` and `addrErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chanEn | input | 1 | Channel enable |
| descAddrWe | input | 1 | Load strobe for the descriptor address |
| descAddrIn | input | AW | Descriptor address value |
| doorbell | input | 1 | Start request |
| rdReq | output | 1 | Read request, held until a response arrives |
| rdAddr | output | AW | Read byte address |
| rdValid | input | 1 | Read response valid |
| rdErr | input | 1 | Read response carries an error |
| rdData | input | 32 | Read response data |
| moveStart | output | 1 | One-cycle start pulse to the data mover |
| moveSrc | output | 32 | Source address for the mover |
| moveDst | output | 32 | Target address for the mover |
| moveCount | output | 24 | Number of transfer units |
| moveCmd | output | 32 | Command word for the mover |
| moveDone | input | 1 | Mover finished the current descriptor |
| busy | output | 1 | Engine is not idle |
| termDone | output | 1 | Sticky: the list finished at an unlinked descriptor |
| termIrq | output | 1 | One-cycle end-of-list interrupt |
| addrErr | output | 1 | Sticky: a fetch read returned an error |

## Verification
Read data returns on the cycle after a request. The eighth word is captured on the edge that accepts it, and `moveStart` rises in the following cycle. After `moveDone` is seen at an edge, the list-end decision is taken one edge later. `termDone`, `termIrq` and the fall of `busy` all follow one edge after that.

All results are therefore sampled on falling clock edges. Final status is read once `busy` is seen low, and interrupt pulses are counted on every falling edge so that a one-cycle pulse is never missed. Disable response is checked at the first falling edge after the rising edge that samples `chanEn` low.

// File: rtl/chain_fetch_pkg.sv
package chain_fetch_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int LINK_UNIT  = 4;   // link offset is in 16-byte units

  // Word positions inside a descriptor (fetch order matters)
  localparam int W_CMD = 0;
  localparam int W_SRC = 1;
  localparam int W_DST = 2;
  localparam int W_CNT = 3;

  // Command word flags used by the sequencer
  localparam int LINK_BIT = 0;
  localparam int TIE_BIT  = 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_ISSUE, ST_WAIT, ST_NEXT, ST_TERM
  } seqState_t;

  typedef struct packed {
    logic             start;
    logic             loadWord;
    logic [IDX_W-1:0] wordIdx;
    logic             follow;
    logic             setTerm;
    logic             setErr;
  } dpStrobe_t;
endpackage

// File: rtl/chain_fetch_ctrl.sv
module chain_fetch_ctrl
  import chain_fetch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic             doorbell,
  input  logic             descAddrWe,
  input  logic             rdValid,
  input  logic             rdErr,
  input  logic             moveDone,
  input  logic             linkFlag,
  output seqState_t        state,
  output dpStrobe_t        strb,
  output logic [IDX_W-1:0] wordIdx,
  output logic             rdReq,
  output logic             moveStart
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  logic armed;

  // Strobes toward the datapath
  always_comb begin
    strb = '0;
    if (chanEn) begin
      unique case (state)
        ST_IDLE:  strb.start = doorbell && armed;
        ST_FETCH: begin
          if (rdValid) begin
            strb.setErr   = rdErr;
            strb.loadWord = !rdErr;
            strb.wordIdx  = wordIdx;
          end
        end
        ST_NEXT:  strb.follow  = linkFlag;
        ST_TERM:  strb.setTerm = 1'b1;
        default:  ;
      endcase
    end
  end

  assign rdReq     = chanEn && (state == ST_FETCH);
  assign moveStart = chanEn && (state == ST_ISSUE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else if (!chanEn) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strb.start) begin
            state   <= ST_FETCH;
            wordIdx <= '0;
          end
        end
        ST_FETCH: begin
          if (rdValid) begin
            if (rdErr) begin
              state <= ST_IDLE;
            end else if (wordIdx == LAST_IDX) begin
              state <= ST_ISSUE;
            end else begin
              wordIdx <= wordIdx + 1'b1;
            end
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT:  if (moveDone) state <= ST_NEXT;
        ST_NEXT: begin
          wordIdx <= '0;
          state   <= linkFlag ? ST_FETCH : ST_TERM;
        end
        ST_TERM:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // A doorbell is honoured once per descriptor-address write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           armed <= 1'b0;
    else if (descAddrWe) armed <= 1'b1;
    else if (strb.start) armed <= 1'b0;
  end
endmodule

// File: rtl/chain_fetch_dp.sv
module chain_fetch_dp
  import chain_fetch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic              descAddrWe,
  input  logic [AW-1:0]     descAddrIn,
  input  logic [WORD_W-1:0] rdData,
  output logic [AW-1:0]     rdAddr,
  output logic [WORD_W-1:0] moveSrc,
  output logic [WORD_W-1:0] moveDst,
  output logic [CNT_W-1:0]  moveCount,
  output logic [WORD_W-1:0] moveCmd,
  output logic              linkFlag,
  output logic              termDone,
  output logic              termIrq,
  output logic              addrErr
);
  localparam int OFF_W  = WORD_W - CNT_W;
  localparam int LINK_W = OFF_W + LINK_UNIT;

  logic [AW-1:0]     descAddr, baseAddr, curDesc;
  logic [WORD_W-1:0] cmdR, srcR, dstR, cntR;
  logic [AW-1:0]     linkOffset;

  assign linkOffset = AW'({cntR[WORD_W-1:CNT_W], LINK_UNIT'(0)});
  assign rdAddr     = curDesc + AW'({wordIdx, 2'b00});
  assign moveSrc    = srcR;
  assign moveDst    = dstR;
  assign moveCount  = cntR[CNT_W-1:0];
  assign moveCmd    = cmdR;
  assign linkFlag   = cmdR[LINK_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           descAddr <= '0;
    else if (descAddrWe) descAddr <= descAddrIn;
  end

  // Chain base is frozen at start; links are relative to it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      curDesc  <= '0;
    end else if (strb.start) begin
      baseAddr <= descAddr;
      curDesc  <= descAddr;
    end else if (strb.follow) begin
      curDesc  <= baseAddr + linkOffset;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdR <= '0;
      srcR <= '0;
      dstR <= '0;
      cntR <= '0;
    end else if (strb.loadWord) begin
      unique case (int'(strb.wordIdx))
        W_CMD:   cmdR <= rdData;
        W_SRC:   srcR <= rdData;
        W_DST:   dstR <= rdData;
        W_CNT:   cntR <= rdData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      termDone <= 1'b0;
      termIrq  <= 1'b0;
      addrErr  <= 1'b0;
    end else begin
      termIrq <= strb.setTerm && cmdR[TIE_BIT];
      if (strb.start) begin
        termDone <= 1'b0;
        addrErr  <= 1'b0;
      end else begin
        if (strb.setTerm) termDone <= 1'b1;
        if (strb.setErr)  addrErr  <= 1'b1;
      end
    end
  end

  logic unusedLinkW;
  assign unusedLinkW = (LINK_W == 0);
endmodule

// File: rtl/chain_fetch_seq.sv
module chain_fetch_seq
  import chain_fetch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              descAddrWe,
  input  logic [AW-1:0]     descAddrIn,
  input  logic              doorbell,
  output logic              rdReq,
  output logic [AW-1:0]     rdAddr,
  input  logic              rdValid,
  input  logic              rdErr,
  input  logic [WORD_W-1:0] rdData,
  output logic              moveStart,
  output logic [WORD_W-1:0] moveSrc,
  output logic [WORD_W-1:0] moveDst,
  output logic [CNT_W-1:0]  moveCount,
  output logic [WORD_W-1:0] moveCmd,
  input  logic              moveDone,
  output logic              busy,
  output logic              termDone,
  output logic              termIrq,
  output logic              addrErr
);
  seqState_t        state;
  dpStrobe_t        strb;
  logic [IDX_W-1:0] wordIdx;
  logic             linkFlag;

  chain_fetch_ctrl ctrl_i (
    .clk, .rstN, .chanEn, .doorbell, .descAddrWe, .rdValid, .rdErr,
    .moveDone, .linkFlag, .state, .strb, .wordIdx, .rdReq, .moveStart
  );

  chain_fetch_dp #(.AW(AW), .CNT_W(CNT_W)) dp_i (
    .clk, .rstN, .strb, .wordIdx, .descAddrWe, .descAddrIn, .rdData,
    .rdAddr, .moveSrc, .moveDst, .moveCount, .moveCmd, .linkFlag,
    .termDone, .termIrq, .addrErr
  );

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/chain_fetch_sva.sv
module chain_fetch_sva #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          chanEn,
  input logic          rdReq,
  input logic [AW-1:0] rdAddr,
  input logic          rdValid,
  input logic          moveStart,
  input logic          busy,
  input logic          termDone,
  input logic          termIrq,
  input logic          addrErr
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdReq && !moveStart));

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdValid && chanEn) |=> (rdReq && $stable(rdAddr)));

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rstN)
    moveStart |=> !moveStart);

  a_r7_irq_with_status: assert property (@(posedge clk) disable iff (!rstN)
    termIrq |-> termDone);

  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    termIrq |=> !termIrq);

  a_r8_error_no_issue: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> !moveStart);

  a_r9_disable_idle: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> !busy);
endmodule

bind chain_fetch_seq chain_fetch_sva #(.AW(AW)) sva_i (
  .clk(clk), .rstN(rstN), .chanEn(chanEn), .rdReq(rdReq), .rdAddr(rdAddr),
  .rdValid(rdValid), .moveStart(moveStart), .busy(busy),
  .termDone(termDone), .termIrq(termIrq), .addrErr(addrErr)
);

// File: tb/chain_fetch_seq_tb_top.sv
`timescale 1ns/1ps
module chain_fetch_seq_tb_top;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chanEn = 1'b0;
  logic        descAddrWe = 1'b0;
  logic [31:0] descAddrIn = '0;
  logic        doorbell = 1'b0;
  logic        rdReq;
  logic [31:0] rdAddr;
  logic        rdValid = 1'b0;
  logic        rdErr = 1'b0;
  logic [31:0] rdData = '0;
  logic        moveStart;
  logic [31:0] moveSrc, moveDst, moveCmd;
  logic [23:0] moveCount;
  logic        moveDone = 1'b0;
  logic        busy, termDone, termIrq, addrErr;

  chain_fetch_seq #(.AW(AW), .CNT_W(24)) dut_i (
    .clk, .rstN, .chanEn, .descAddrWe, .descAddrIn, .doorbell,
    .rdReq, .rdAddr, .rdValid, .rdErr, .rdData,
    .moveStart, .moveSrc, .moveDst, .moveCount, .moveCmd, .moveDone,
    .busy, .termDone, .termIrq, .addrErr
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int issues = 0;
  int reads = 0;
  int irqCount = 0;
  int doneCnt = 0;
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  logic [11:0] issueLog [16];
  logic [31:0] mem [128];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Descriptor image: source/target encode the descriptor's own address
  task automatic putDesc(input int addr, input bit link, input bit tie,
                         input logic [7:0] off);
    int i = addr >> 2;
    mem[i]   = 32'h00C0_5300 | {30'd0, tie, link};
    mem[i+1] = 32'hA000_0000 | addr;
    mem[i+2] = 32'hB000_0000 | addr;
    mem[i+3] = {off, 24'(addr + 5)};
    for (int k = 4; k < 8; k++) mem[i+k] = 32'hDEAD_0000 | k;
  endtask

  // Read responder: one cycle to answer, one idle cycle between words
  always @(negedge clk) begin
    if (rdValid) begin
      rdValid <= 1'b0;
    end else if (rdReq) begin
      reads++;
      rdValid <= 1'b1;
      rdData  <= mem[rdAddr[8:2]];
      rdErr   <= (rdAddr == errAddr);
    end
  end

  // Data mover model; checks the presented fields (R3, R4)
  always @(negedge clk) begin
    moveDone <= 1'b0;
    if (termIrq) irqCount++;
    if (moveStart) begin
      automatic int a = int'(moveSrc[8:0]);
      if (issues < 16) issueLog[issues] = moveSrc[11:0];
      issues++;
      chk(moveCmd == mem[a>>2], "R3 command word", moveCmd, mem[a>>2]);
      chk(moveDst == (32'hB000_0000 | a), "R3 target word", moveDst,
          32'hB000_0000 | a);
      chk(moveCount == mem[(a>>2)+3][23:0], "R4 count field",
          {8'd0, moveCount}, {8'd0, mem[(a>>2)+3][23:0]});
      doneCnt = 3;
    end else if (doneCnt != 0) begin
      doneCnt--;
      if (doneCnt == 0) moveDone <= 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=idle", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  task automatic launch(input logic [31:0] addr);
    issues = 0; reads = 0; irqCount = 0;
    descAddrIn = addr;
    descAddrWe = 1'b1;
    @(negedge clk);
    descAddrWe = 1'b0;
    doorbell   = 1'b1;
    @(negedge clk);
    doorbell   = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // {start[11:0], issues[3:0], lastDesc[11:0], term, irq, err, 0}
  localparam logic [31:0] VECS [4] = '{
    32'h0003_040C,  // three linked, base-relative hop, irq
    32'h0801_0808,  // single, no irq enable
    32'h1001_1002,  // read error on second descriptor
    32'h0003_040C   // rerun: stale error must be cleared
  };

  initial begin
    for (int k = 0; k < 128; k++) mem[k] = '0;
    putDesc(12'h000, 1'b1, 1'b1, 8'd2);
    putDesc(12'h020, 1'b1, 1'b1, 8'd4);   // base+0x40, not 0x20+0x40
    putDesc(12'h040, 1'b0, 1'b1, 8'd0);
    putDesc(12'h080, 1'b0, 1'b0, 8'd0);
    putDesc(12'h100, 1'b1, 1'b1, 8'd2);
    putDesc(12'h120, 1'b0, 1'b1, 8'd0);
    putDesc(12'h180, 1'b1, 1'b1, 8'd2);
    putDesc(12'h1A0, 1'b1, 1'b1, 8'd0);   // zero offset: back to base
    errAddr = 32'h0000_012C;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !rdReq && !moveStart, "R1 idle after reset",
        {29'd0, busy, rdReq, moveStart}, 32'd0);
    chk(!termDone && !termIrq && !addrErr, "R1 flags after reset",
        {29'd0, termDone, termIrq, addrErr}, 32'd0);

    // R2: doorbell while disabled after an address write is ignored
    descAddrIn = 32'h080; descAddrWe = 1'b1;
    @(negedge clk);
    descAddrWe = 1'b0; doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
    @(negedge clk);
    chk(!busy && !rdReq, "R2 doorbell with channel disabled",
        {30'd0, busy, rdReq}, 32'd0);
    chanEn = 1'b1;
    @(negedge clk);

    foreach (VECS[v]) begin
      automatic logic [31:0] vec = VECS[v];
      launch({20'd0, vec[31:20]});
      waitIdle();
      repeat (2) @(negedge clk);
      chk(issues == int'(vec[19:16]), "R5 R8 descriptors issued",
          issues, vec[19:16]);
      chk(issueLog[issues-1] == vec[15:4], "R5 last descriptor address",
          issueLog[issues-1], vec[15:4]);
      chk(reads == (vec[1] ? 12 : issues * 8), "R3 eight reads each",
          reads, vec[1] ? 12 : issues * 8);
      chk(termDone == vec[3], "R7 R10 end-of-list status", termDone, vec[3]);
      chk(irqCount == int'(vec[2]), "R7 interrupt pulses", irqCount, vec[2]);
      chk(addrErr == vec[1], "R8 R10 address error flag", addrErr, vec[1]);
    end

    // R2: doorbell with no fresh address write is ignored
    doorbell = 1'b1;
    @(negedge clk);
    doorbell = 1'b0;
    @(negedge clk);
    chk(!busy && !rdReq, "R2 doorbell without address load",
        {30'd0, busy, rdReq}, 32'd0);

    // R6: ring of two descriptors keeps looping from the base
    launch(32'h180);
    begin
      int n = 0;
      while (issues < 5 && n < 4000) begin
        @(negedge clk);
        n++;
      end
    end
    chk(issueLog[0] == 12'h180 && issueLog[2] == 12'h180 &&
        issueLog[4] == 12'h180, "R6 ring returns to base",
        {20'd0, issueLog[2]}, 32'h180);
    chk(issueLog[1] == 12'h1A0 && issueLog[3] == 12'h1A0,
        "R5 ring hop to second descriptor", {20'd0, issueLog[3]}, 32'h1A0);
    chk(!termDone && irqCount == 0, "R6 no end-of-list while linked",
        {31'd0, termDone} + irqCount, 32'd0);

    // R9: disable stops the engine at the next edge
    chanEn = 1'b0;
    @(negedge clk);
    chk(!busy && !rdReq && !moveStart, "R9 idle after disable",
        {29'd0, busy, rdReq, moveStart}, 32'd0);
    repeat (10) @(negedge clk);
    chk(!busy && !termDone, "R9 stays idle after disable",
        {30'd0, busy, termDone}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule